// File: doc/BRIEF.md
# Interrupt Mitigation Delay Controller

This block stands between the interrupt cause logic of a network controller and its single interrupt line. It keeps a cause register and a mask register. The pending set is cause AND mask, and the line tracks whether that set is non-zero. When mitigation is enabled, the block limits the interrupt rate with one shared countdown timer. The first rising edge passes at once and starts a window. Any new rising edge inside that window waits until the window closes. When the timer expires the block evaluates the pending set again, and this can open another window.

The window length is the smallest non-zero delay among three candidates. The first is a throttle interval, which always qualifies. The second is a receive absolute delay. It qualifies only when the receive delay timer register is non-zero and the receive-timer cause is pending. The third is a transmit absolute delay. It qualifies only when a transmit descriptor with its delay-enable bit set was seen since the last computation, and a transmit cause is pending. The two absolute delays are in 1024 ns units and are multiplied by 4. The throttle interval is already in the common 256 ns tick, which a prescaler of `TICK_DIV` core cycles produces.

The control path is a four-state machine. The line level and the timer activity are its two state bits:

- `ST_LOW_IDLE`: line low, timer idle.
- `ST_HIGH_IDLE`: line high, timer idle.
- `ST_LOW_HOLD`: line low, timer running.
- `ST_HIGH_HOLD`: line high, timer running.

The transitions are:

- ARM_RISE: `ST_LOW_IDLE` to `ST_HIGH_HOLD`, taken on a rise when the computed delay is non-zero.
- FREE_RISE: `ST_LOW_IDLE` to `ST_HIGH_IDLE`, taken on a rise when the computed delay is zero.
- DROP: a HIGH state goes to the LOW state with the same timer state when the pending set empties.
- HOLD_RISE: `ST_LOW_HOLD` stays where it is while pending is non-zero before expiry.
- EXPIRE: a HOLD state at the end of its window goes to the matching IDLE state. If pending is non-zero at that moment, ARM_RISE or FREE_RISE is taken from `ST_LOW_HOLD` instead.
- BYPASS: with the enable low, the machine goes to `ST_HIGH_IDLE` or `ST_LOW_IDLE` from any state, following the pending set.

Top module: `irq_moderator`

## Requirements
- R1: The pending set is cause AND mask. Register addresses: 0 is cause (a write clears the bits written as 1, and cause_set events OR in and win over a clear in the same cycle); 1 sets mask bits on write and reads the mask; 2 clears mask bits on write. When the pending set becomes zero, irq_o falls one cycle after the register update.
- R2: A rising edge seen while the timer runs keeps irq_o low until the cycle after expiry. A rising edge seen with the timer idle raises irq_o one cycle after the register update.
- R3: The loaded delay is the minimum of the qualifying non-zero candidates. Zero candidates are ignored. If no candidate is non-zero, the line rises and no window is started.
- R4: The transmit absolute delay (address 5) qualifies, times 4, only when the descriptor delay-enable latch is set and cause bit 0 or cause bit 1 is pending.
- R5: The receive absolute delay (address 4) qualifies, times 4, only when the receive delay timer register (address 6) is non-zero and cause bit 7 is pending.
- R6: The throttle interval (address 3) qualifies whenever it is non-zero, in raw units. A delay of D holds the line for D*TICK_DIV core cycles, counted from the arming edge.
- R7: Registers 3 to 6 keep only the low 16 bits of a write and read back zero-extended.
- R8: The descriptor delay-enable latch ORs in desc_ide on each desc_valid cycle. Every delay computation clears it, whether or not a window was armed.
- R9: At expiry the pending set is evaluated again. If it is non-zero, a new delay computation runs and can start a new window.
- R10: Reset clears the timer, the line, the latch, cause and mask, and registers 3 to 6.
- R11: With mit_en low, irq_o follows the pending set one cycle later, no window is armed and a running window is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mit_en | input | 1 | Mitigation enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| cause_set | input | 32 | Cause bits raised by the receive and transmit paths |
| desc_valid | input | 1 | A transmit descriptor is processed this cycle |
| desc_ide | input | 1 | Delay-enable bit of that descriptor |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench targets the exact expiry cycle by checking the line one cycle before and at the release. A timer that is off by one prescaler period or one tick would release at the wrong cycle. It shows that the receive delay wins over a zero throttle and that a 17-bit write is cut to 16 bits: a design that kept the high bit, or that let the unlatched transmit delay qualify, would release far too late or too early. It then shows that the delay-enable latch clears after a computation, because the next rise passes without a window; a design that kept the latch would hold that edge. Finally it resets in the middle of a window and drops the enable during a window, where a design that kept the timer running would keep a later edge low.

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CAUSE    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK_SET = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 3'd2;
    localparam logic [ADDR_W-1:0] A_THROTTLE = 3'd3;
    localparam logic [ADDR_W-1:0] A_RX_ABS   = 3'd4;
    localparam logic [ADDR_W-1:0] A_TX_ABS   = 3'd5;
    localparam logic [ADDR_W-1:0] A_RX_TMR   = 3'd6;

    localparam int N_DLY = 4;

    // bit 0: line level, bit 1: timer running
    typedef enum logic [1:0] {
        ST_LOW_IDLE  = 2'b00,
        ST_HIGH_IDLE = 2'b01,
        ST_LOW_HOLD  = 2'b10,
        ST_HIGH_HOLD = 2'b11
    } mit_state_e;

endpackage

// File: rtl/irq_mod_regs.sv
module irq_mod_regs
    import irq_mod_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DLY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [DW-1:0]     cause_set,
    input  logic              desc_valid,
    input  logic              desc_ide,
    input  logic              calc_done,
    output logic [DW-1:0]     pending,
    output logic [DLY_W-1:0]  throttle,
    output logic [DLY_W-1:0]  rx_abs,
    output logic [DLY_W-1:0]  tx_abs,
    output logic [DLY_W-1:0]  rx_tmr,
    output logic              ide_latched
);

    logic [DW-1:0]    cause_q;
    logic [DW-1:0]    mask_q;
    logic [DLY_W-1:0] dly_q [N_DLY];
    logic             ide_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (wr_en && wr_addr == A_CAUSE) begin
            cause_q <= (cause_q & ~wr_data) | cause_set;
        end else begin
            cause_q <= cause_q | cause_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && wr_addr == A_MASK_SET) begin
            mask_q <= mask_q | wr_data;
        end else if (wr_en && wr_addr == A_MASK_CLR) begin
            mask_q <= mask_q & ~wr_data;
        end
    end

    for (genvar g = 0; g < N_DLY; g++) begin : g_dly
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_THROTTLE) + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dly_q[g] <= '0;
            end else if (wr_en && wr_addr == MY_ADDR) begin
                dly_q[g] <= wr_data[DLY_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ide_q <= 1'b0;
        end else begin
            ide_q <= (calc_done ? 1'b0 : ide_q) | (desc_valid & desc_ide);
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CAUSE:    rd_data = cause_q;
            A_MASK_SET: rd_data = mask_q;
            A_MASK_CLR: rd_data = mask_q;
            A_THROTTLE: rd_data = DW'(dly_q[0]);
            A_RX_ABS:   rd_data = DW'(dly_q[1]);
            A_TX_ABS:   rd_data = DW'(dly_q[2]);
            A_RX_TMR:   rd_data = DW'(dly_q[3]);
            default:    rd_data = '0;
        endcase
    end

    assign pending     = cause_q & mask_q;
    assign throttle    = dly_q[0];
    assign rx_abs      = dly_q[1];
    assign tx_abs      = dly_q[2];
    assign rx_tmr      = dly_q[3];
    assign ide_latched = ide_q;

endmodule

// File: rtl/irq_mod_delay.sv
module irq_mod_delay #(
    parameter int DLY_W = 16,
    parameter int CNT_W = 20
) (
    input  logic             pend_tx,
    input  logic             pend_rx,
    input  logic             ide_latched,
    input  logic [DLY_W-1:0] throttle,
    input  logic [DLY_W-1:0] rx_abs,
    input  logic [DLY_W-1:0] tx_abs,
    input  logic [DLY_W-1:0] rx_tmr,
    output logic [CNT_W-1:0] delay
);

    localparam int N_CAND = 3;

    logic [CNT_W-1:0] cand [N_CAND];

    // absolute delays are in quarter-rate units: scale by 4
    assign cand[0] = CNT_W'(throttle);
    assign cand[1] = (pend_rx && rx_tmr != '0) ? CNT_W'({rx_abs, 2'b00}) : '0;
    assign cand[2] = (pend_tx && ide_latched)  ? CNT_W'({tx_abs, 2'b00}) : '0;

    always_comb begin
        delay = '0;
        for (int i = 0; i < N_CAND; i++) begin
            if (cand[i] != '0 && (delay == '0 || cand[i] < delay)) begin
                delay = cand[i];
            end
        end
    end

endmodule

// File: rtl/irq_mod_timer.sv
module irq_mod_timer #(
    parameter int CNT_W    = 20,
    parameter int TICK_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop,
    output logic             busy,
    output logic             expire
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             wrap;

    assign wrap = (pre_q == PRE_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (stop) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
            pre_q <= '0;
        end else if (cnt_q != '0) begin
            if (wrap) begin
                pre_q <= '0;
                cnt_q <= cnt_q - CNT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    assign busy   = (cnt_q != '0);
    assign expire = (cnt_q == CNT_W'(1)) && wrap;

endmodule

// File: rtl/irq_mod_fsm.sv
module irq_mod_fsm
    import irq_mod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mit_en,
    input  logic pend_any,
    input  logic expire,
    input  logic delay_nz,
    output logic line,
    output logic hold,
    output logic arm,
    output logic calc,
    output logic stop
);

    mit_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_LOW_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (!mit_en) begin
            st_d = pend_any ? ST_HIGH_IDLE : ST_LOW_IDLE;
        end else begin
            unique case (st_q)
                ST_LOW_IDLE: begin
                    if (pend_any) st_d = delay_nz ? ST_HIGH_HOLD : ST_HIGH_IDLE;
                end
                ST_HIGH_IDLE: begin
                    if (!pend_any) st_d = ST_LOW_IDLE;
                end
                ST_LOW_HOLD: begin
                    if (expire) begin
                        if (pend_any) st_d = delay_nz ? ST_HIGH_HOLD : ST_HIGH_IDLE;
                        else          st_d = ST_LOW_IDLE;
                    end
                end
                ST_HIGH_HOLD: begin
                    if (pend_any) st_d = expire ? ST_HIGH_IDLE : ST_HIGH_HOLD;
                    else          st_d = expire ? ST_LOW_IDLE  : ST_LOW_HOLD;
                end
            endcase
        end
    end

    always_comb begin
        calc = mit_en && pend_any &&
               (st_q == ST_LOW_IDLE || (st_q == ST_LOW_HOLD && expire));
        arm  = calc && delay_nz;
        stop = !mit_en;
        line = st_q[0];
        hold = st_q[1];
    end

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import irq_mod_pkg::*;
#(
    parameter int DW       = 32,
    parameter int DLY_W    = 16,
    parameter int CNT_W    = 20,
    parameter int TICK_DIV = 64,
    parameter int TXDW_BIT = 0,
    parameter int TXQE_BIT = 1,
    parameter int RXT_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mit_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [DW-1:0]     cause_set,
    input  logic              desc_valid,
    input  logic              desc_ide,
    output logic              irq_o
);

    logic [DW-1:0]    pend_w;
    logic [DLY_W-1:0] thr_w, rxa_w, txa_w, rxt_w;
    logic             ide_w;
    logic [CNT_W-1:0] delay_w;
    logic             calc_w, arm_w, stop_w, fsm_hold;
    logic             tmr_busy, tmr_expire;

    irq_mod_regs #(.DW(DW), .DLY_W(DLY_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cause_set(cause_set), .desc_valid(desc_valid), .desc_ide(desc_ide),
        .calc_done(calc_w), .pending(pend_w),
        .throttle(thr_w), .rx_abs(rxa_w), .tx_abs(txa_w), .rx_tmr(rxt_w),
        .ide_latched(ide_w)
    );

    irq_mod_delay #(.DLY_W(DLY_W), .CNT_W(CNT_W)) delay_i (
        .pend_tx(pend_w[TXDW_BIT] | pend_w[TXQE_BIT]),
        .pend_rx(pend_w[RXT_BIT]),
        .ide_latched(ide_w),
        .throttle(thr_w), .rx_abs(rxa_w), .tx_abs(txa_w), .rx_tmr(rxt_w),
        .delay(delay_w)
    );

    irq_mod_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) timer_i (
        .clk(clk), .rst_n(rst_n),
        .load(arm_w), .load_val(delay_w), .stop(stop_w),
        .busy(tmr_busy), .expire(tmr_expire)
    );

    irq_mod_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .mit_en(mit_en),
        .pend_any(pend_w != '0), .expire(tmr_expire),
        .delay_nz(delay_w != '0),
        .line(irq_o), .hold(fsm_hold),
        .arm(arm_w), .calc(calc_w), .stop(stop_w)
    );

endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mit_en,
    input logic          irq_o,
    input logic [DW-1:0] pending,
    input logic          timer_busy,
    input logic          timer_expire,
    input logic          hold_st
);

    // R1
    line_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && pending == '0) |=> !irq_o);

    // R2
    edge_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mit_en && !irq_o && timer_busy && !timer_expire) |=> !irq_o);

    // R2
    timer_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_busy == hold_st);

    // R11
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mit_en |=> (irq_o == ($past(pending) != '0)) && !timer_busy);

    // R10
    reset_clean_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_o && !timer_busy));

endmodule

bind irq_moderator irq_moderator_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .mit_en(mit_en), .irq_o(irq_o),
    .pending(pend_w), .timer_busy(tmr_busy), .timer_expire(tmr_expire),
    .hold_st(fsm_hold)
);

// File: tb/irq_moderator_tb.sv
module irq_moderator_tb_top;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mit_en = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] cause_set = '0;
    logic          desc_valid = 1'b0;
    logic          desc_ide = 1'b0;
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_moderator #(.TICK_DIV(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .mit_en(mit_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cause_set(cause_set), .desc_valid(desc_valid), .desc_ide(desc_ide),
        .irq_o(irq_o)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  addr;
        logic [19:0] data;
        logic [7:0]  cset;
        logic        txd;
        logic [7:0]  w;
        logic        exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd1, 20'h00083, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1},  // R1 mask 0,1,7
        '{1'b1, 3'd3, 20'h00003, 8'h00, 1'b0, 8'd2,  1'b0, 4'd6},  // R6 throttle 3
        '{1'b0, 3'd0, 20'h00000, 8'h80, 1'b0, 8'd2,  1'b1, 4'd2},  // R2 first edge passes
        '{1'b1, 3'd0, 20'h00080, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1},  // R1 clear drops line
        '{1'b0, 3'd0, 20'h00000, 8'h80, 1'b0, 8'd2,  1'b0, 4'd2},  // R2 held
        '{1'b0, 3'd0, 20'h00000, 8'h00, 1'b0, 8'd7,  1'b0, 4'd6},  // R6 still held
        '{1'b0, 3'd0, 20'h00000, 8'h00, 1'b0, 8'd1,  1'b1, 4'd9},  // R9 released at expiry
        '{1'b1, 3'd0, 20'h00080, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1},
        '{1'b0, 3'd0, 20'h00000, 8'h00, 1'b0, 8'd12, 1'b0, 4'd9},
        '{1'b1, 3'd3, 20'h00000, 8'h00, 1'b0, 8'd1,  1'b0, 4'd3},  // R3 throttle 0
        '{1'b1, 3'd6, 20'h00001, 8'h00, 1'b0, 8'd1,  1'b0, 4'd5},  // R5 rx timer on
        '{1'b1, 3'd4, 20'h10002, 8'h00, 1'b0, 8'd1,  1'b0, 4'd7},  // R7 cut to 2
        '{1'b1, 3'd5, 20'h00001, 8'h00, 1'b0, 8'd1,  1'b0, 4'd4},  // R4 tx abs 1
        '{1'b0, 3'd0, 20'h00000, 8'h80, 1'b0, 8'd2,  1'b1, 4'd5},  // R5 arms 8 ticks
        '{1'b1, 3'd0, 20'h00080, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1},
        '{1'b0, 3'd0, 20'h00000, 8'h80, 1'b0, 8'd29, 1'b0, 4'd4},  // R4 tx not latched
        '{1'b0, 3'd0, 20'h00000, 8'h00, 1'b0, 8'd1,  1'b1, 4'd5},  // R5 32-cycle window
        '{1'b1, 3'd0, 20'h00080, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1},
        '{1'b0, 3'd0, 20'h00000, 8'h00, 1'b1, 8'd1,  1'b0, 4'd8},  // R8 latch ide
        '{1'b0, 3'd0, 20'h00000, 8'h00, 1'b0, 8'd30, 1'b0, 4'd9},
        '{1'b0, 3'd0, 20'h00000, 8'h01, 1'b0, 8'd2,  1'b1, 4'd4},  // R4 arms 4 ticks
        '{1'b1, 3'd0, 20'h00001, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1},
        '{1'b0, 3'd0, 20'h00000, 8'h01, 1'b0, 8'd13, 1'b0, 4'd4},  // R4 held 16 cycles
        '{1'b0, 3'd0, 20'h00000, 8'h00, 1'b0, 8'd1,  1'b1, 4'd4},
        '{1'b1, 3'd0, 20'h00001, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1},
        '{1'b0, 3'd0, 20'h00000, 8'h01, 1'b0, 8'd2,  1'b1, 4'd8},  // R8 latch cleared
        '{1'b1, 3'd0, 20'h00001, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1},
        '{1'b0, 3'd0, 20'h00000, 8'h01, 1'b0, 8'd2,  1'b1, 4'd3},  // R3 no window
        '{1'b1, 3'd2, 20'h00001, 8'h00, 1'b0, 8'd2,  1'b0, 4'd1}   // R1 mask clear
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic raise(input logic [DW-1:0] c);
        cause_set = c;
        @(negedge clk);
        cause_set = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R10 reset state
        chk("R10 irq after reset", DW'(irq_o), 0);
        rd(3'd0, d); chk("R10 cause after reset", d, 0);
        rd(3'd1, d); chk("R10 mask after reset", d, 0);

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i].we; wr_addr = VEC[i].addr; wr_data = DW'(VEC[i].data);
            cause_set = DW'(VEC[i].cset);
            desc_valid = VEC[i].txd; desc_ide = VEC[i].txd;
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0; cause_set = '0;
            desc_valid = 1'b0; desc_ide = 1'b0;
            step(int'(VEC[i].w) - 1);
            n_chk++;
            if (irq_o !== VEC[i].exp) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: actual %0b expected %0b",
                         VEC[i].rq, i, irq_o, VEC[i].exp);
            end
        end

        // R7 readback truncation
        wr(3'd3, 32'h0001_2345);
        rd(3'd3, d); chk("R7 throttle readback", d, 32'h2345);
        wr(3'd4, 32'hFFFF_0001);
        rd(3'd4, d); chk("R7 rx abs readback", d, 32'h0001);
        rd(3'd1, d); chk("R1 mask readback", d, 32'h82);

        // R10 reset in the middle of a window
        do_reset();
        wr(3'd3, 32'd100);
        wr(3'd1, 32'h1);
        raise(32'h1); step(1);
        chk("R2 first edge passes", DW'(irq_o), 1);
        wr(3'd0, 32'h1); step(1);
        chk("R1 line drops", DW'(irq_o), 0);
        raise(32'h1); step(2);
        chk("R2 edge held in window", DW'(irq_o), 0);
        do_reset();
        chk("R10 irq low after reset", DW'(irq_o), 0);
        rd(3'd0, d); chk("R10 cause cleared", d, 0);
        rd(3'd3, d); chk("R10 throttle cleared", d, 0);
        wr(3'd3, 32'd100);
        wr(3'd1, 32'h1);
        raise(32'h1); step(1);
        chk("R10 timer stopped by reset", DW'(irq_o), 1);

        // R11 bypass cancels the window
        mit_en = 1'b0;
        wr(3'd0, 32'h1); step(1);
        chk("R11 follows pending low", DW'(irq_o), 0);
        raise(32'h1); step(1);
        chk("R11 rise not held", DW'(irq_o), 1);
        mit_en = 1'b1;
        wr(3'd0, 32'h1); step(1);
        chk("R11 drop after re-enable", DW'(irq_o), 0);
        raise(32'h1); step(1);
        chk("R11 window cancelled", DW'(irq_o), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule